// File: doc/BRIEF.md
# ADB Transaction Sequencer

This block is the host-side controller for a byte-serial desktop-bus transceiver. It takes one request (a command byte, 1 to 14 data bytes, a byte count and a reply-expected flag). It hands the bytes one at a time to a shift-register model and advances a two-bit phase code after every completed byte.

Once the packet has gone out, the shifter is turned to input. When a reply is expected, the sequencer collects it byte by byte. A byte that arrives while the block is idle starts an unsolicited reception, such as autopoll data.

The end of a reception is found by looking at the received value together with the active-low controller status, on this byte and on the byte before it. From that pattern the block tells apart four outcomes:
- a normal end;
- an end with a service request (SRQ);
- a bus timeout;
- a timeout with SRQ.

Each reception ends with a one-cycle completion pulse that carries a length and the flags.

Top module: `adb_seq`

## Requirements
- R1: While reset is applied, and after it: the phase code is 11 (idle), the shifter is in input mode (`sr_dir_o`=0), the reply length and every reply byte are 0, all pulse outputs are low, and `req_ready_o` is 1.
- R2: A request with 1 to 14 data bytes, presented while the block is ready, is taken on that edge. On the next cycle `sr_out_o` holds the command byte, `sr_dir_o`=1 and the phase code is 00 (command).
- R3: A request with 0 or more than 14 data bytes gives a one-cycle `req_rej_o` pulse and leaves the phase code at 11 and the shifter in input mode.
- R4: While sending, each byte-complete strobe loads the next data byte (data byte k sits at `req_data_i[8k+7:8k]`). The phase moves from 00 to 01 (even) after the command byte, and after that alternates between 01 and 10 (odd).
- R5: After the strobe for the last data byte of a request that expects no reply, the shifter goes to input and the phase to 11. `done_o` pulses with length 0, both flags clear and `rply_sol_o`=0.
- R6: After the strobe for the last data byte of a request that expects a reply, the shifter goes to input and the phase to 01. No done pulse is given.
- R7: Each received byte that does not end the reception is stored in order: byte k of the reply sits at `rply_data_o[8k+7:8k]`. After each stored byte the phase goes from 11 to 01, or otherwise alternates between 01 and 10. A value of 0x00 received with status high is stored as data.
- R8: A first received byte of 0xFF with status high ends the reception with timeout set, SRQ clear and length 0.
- R9: A byte of 0xFF with status low on both it and the previous byte ends the reception with timeout and SRQ set and length 0.
- R10: A byte of 0x00 with status low ends the reception without being stored, and the length is the count of stored bytes. SRQ is set only when the status was also low on the previous byte.
- R11: At most 15 bytes are stored. Any further data bytes are dropped, and the length stays at 15.
- R12: A reception that starts from idle reports `rply_sol_o`=0. A reception that follows a reply-expecting request reports `rply_sol_o`=1.
- R13: `done_o` lasts one cycle and then leaves the phase at 11 with the shifter in input mode. `req_ready_o` is low whenever the phase is not 11, and a request presented while the block is busy has no effect on `sr_out_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle and able to take a request |
| req_cmd_i | input | 8 | Command byte |
| req_data_i | input | MAX_TX*8 | Data bytes, byte k at bits 8k+7:8k |
| req_len_i | input | TLW | Number of data bytes |
| req_reply_i | input | 1 | A reply is expected |
| req_rej_o | output | 1 | One-cycle pulse: request length out of range |
| sr_done_i | input | 1 | Byte-complete strobe from the shifter |
| sr_in_i | input | 8 | Byte received by the shifter |
| sr_out_o | output | 8 | Byte for the shifter to send |
| sr_dir_o | output | 1 | Shifter direction, 1 = output |
| st_o | output | 2 | Phase code: 00 command, 01 even, 10 odd, 11 idle |
| ctl_n_i | input | 1 | Controller status, active low |
| done_o | output | 1 | One-cycle completion pulse |
| tmo_o | output | 1 | Bus timeout, valid with done_o |
| srq_o | output | 1 | Service request, valid with done_o |
| rply_sol_o | output | 1 | Last reception answered a request |
| rply_len_o | output | RLW | Number of stored reply bytes |
| rply_data_o | output | MAX_RX*8 | Reply bytes, byte k at bits 8k+7:8k |

## Verification
Outgoing packets are tried with and without a reply, so that the phase code after the last byte (idle or even) shows which of the two completion paths was taken. Incoming byte patterns vary the status on the final and the second-to-last byte. This separates a plain end from an end with SRQ, a bare timeout from a timeout with SRQ, and a stored 0x00 from a terminating one. A reply longer than the store, a reception started from idle, out-of-range lengths and a request raised mid-packet check the saturation, the solicited flag, rejection and the busy guard.

// File: rtl/adb_seq_pkg.sv
package adb_seq_pkg;
  typedef enum logic [1:0] {
    ST_CMD  = 2'b00,
    ST_EVEN = 2'b01,
    ST_ODD  = 2'b10,
    ST_IDLE = 2'b11
  } adb_st_e;

  typedef enum logic [1:0] {PH_IDLE, PH_TX, PH_RX} phase_e;

  typedef enum logic [2:0] {
    RK_STORE,
    RK_END,
    RK_END_SRQ,
    RK_TMO,
    RK_TMO_SRQ
  } rx_kind_e;
endpackage

// File: rtl/adb_seq_txsel.sv
module adb_seq_txsel #(
  parameter int NB = 14,
  parameter int IW = 4
) (
  input  logic [NB*8-1:0] data_i,
  input  logic [IW-1:0]   idx_i,
  output logic [7:0]      byte_o
);
  always_comb begin
    byte_o = '0;
    for (int k = 0; k < NB; k++) begin
      if (idx_i == IW'(k)) byte_o = data_i[k*8 +: 8];
    end
  end
endmodule

// File: rtl/adb_seq_rxcls.sv
module adb_seq_rxcls
  import adb_seq_pkg::*;
(
  input  logic       first_i,
  input  logic [7:0] byte_i,
  input  logic       ctl_n_i,
  input  logic       prev_ctl_n_i,
  output rx_kind_e   kind_o
);
  always_comb begin
    kind_o = RK_STORE;
    if (first_i && ctl_n_i && byte_i == 8'hFF)
      kind_o = RK_TMO;
    else if (!ctl_n_i && !prev_ctl_n_i && byte_i == 8'hFF)
      kind_o = RK_TMO_SRQ;
    else if (!ctl_n_i && byte_i == 8'h00)
      kind_o = prev_ctl_n_i ? RK_END : RK_END_SRQ;
  end
endmodule

// File: rtl/adb_seq_rxbuf.sv
module adb_seq_rxbuf #(
  parameter int DEPTH = 15,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               wr_i,
  input  logic [7:0]         wdata_i,
  output logic [DEPTH*8-1:0] data_o,
  output logic [CW-1:0]      cnt_o
);
  logic [CW-1:0] cnt_q, base;
  logic          full;

  assign base  = clr_i ? '0 : cnt_q;
  assign full  = (base == CW'(DEPTH));
  assign cnt_o = cnt_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [7:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               ent_q <= '0;
      else if (wr_i && !full && base == CW'(g))  ent_q <= wdata_i;
      else if (clr_i)                            ent_q <= '0;
    end
    assign data_o[g*8 +: 8] = ent_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (wr_i && !full)  cnt_q <= base + 1'b1;
    else if (clr_i)          cnt_q <= '0;
  end
endmodule

// File: rtl/adb_seq.sv
module adb_seq
  import adb_seq_pkg::*;
#(
  parameter int MAX_TX = 14,
  parameter int MAX_RX = 15,
  parameter int TLW    = $clog2(MAX_TX + 2),
  parameter int RLW    = $clog2(MAX_RX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [7:0]          req_cmd_i,
  input  logic [MAX_TX*8-1:0] req_data_i,
  input  logic [TLW-1:0]      req_len_i,
  input  logic                req_reply_i,
  output logic                req_rej_o,
  input  logic                sr_done_i,
  input  logic [7:0]          sr_in_i,
  output logic [7:0]          sr_out_o,
  output logic                sr_dir_o,
  output logic [1:0]          st_o,
  input  logic                ctl_n_i,
  output logic                done_o,
  output logic                tmo_o,
  output logic                srq_o,
  output logic                rply_sol_o,
  output logic [RLW-1:0]      rply_len_o,
  output logic [MAX_RX*8-1:0] rply_data_o
);
  phase_e              phase_q;
  adb_st_e             st_q;
  logic                dir_q, rexp_q, first_q, prevctl_q, sol_q;
  logic                done_q, tmo_q, srq_q, rej_q;
  logic [7:0]          out_q, tx_byte;
  logic [TLW-1:0]      idx_q, len_q;
  logic [MAX_TX*8-1:0] data_q;

  logic     rx_active, first_eff, prev_eff, len_ok, tx_last, buf_clr, buf_wr;
  rx_kind_e kind;

  // a byte while idle opens an unsolicited reception
  assign rx_active = sr_done_i && (phase_q == PH_IDLE || phase_q == PH_RX);
  assign first_eff = (phase_q == PH_IDLE) || first_q;
  assign prev_eff  = (phase_q == PH_IDLE) ? 1'b1 : prevctl_q;
  assign len_ok    = (req_len_i != '0) && (req_len_i <= TLW'(MAX_TX));
  assign tx_last   = (phase_q == PH_TX) && sr_done_i && (idx_q == len_q);

  adb_seq_txsel #(.NB(MAX_TX), .IW(TLW)) u_txsel (
    .data_i(data_q), .idx_i(idx_q), .byte_o(tx_byte)
  );

  adb_seq_rxcls u_rxcls (
    .first_i(first_eff), .byte_i(sr_in_i), .ctl_n_i(ctl_n_i),
    .prev_ctl_n_i(prev_eff), .kind_o(kind)
  );

  assign buf_clr = tx_last
                || (rx_active && phase_q == PH_IDLE)
                || (rx_active && kind == RK_TMO_SRQ);
  assign buf_wr  = rx_active && kind == RK_STORE;

  adb_seq_rxbuf #(.DEPTH(MAX_RX), .CW(RLW)) u_rxbuf (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(buf_clr), .wr_i(buf_wr),
    .wdata_i(sr_in_i), .data_o(rply_data_o), .cnt_o(rply_len_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      st_q      <= ST_IDLE;
      dir_q     <= 1'b0;
      out_q     <= '0;
      idx_q     <= '0;
      len_q     <= '0;
      rexp_q    <= 1'b0;
      data_q    <= '0;
      first_q   <= 1'b0;
      prevctl_q <= 1'b1;
      sol_q     <= 1'b0;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
      srq_q     <= 1'b0;
      rej_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      srq_q  <= 1'b0;
      rej_q  <= 1'b0;
      if (rx_active) begin
        if (phase_q == PH_IDLE) sol_q <= 1'b0;
        if (kind == RK_STORE) begin
          phase_q   <= PH_RX;
          first_q   <= 1'b0;
          prevctl_q <= ctl_n_i;
          st_q      <= (st_q == ST_IDLE) ? ST_EVEN : adb_st_e'(~st_q);
        end else begin
          phase_q <= PH_IDLE;
          st_q    <= ST_IDLE;
          done_q  <= 1'b1;
          tmo_q   <= (kind == RK_TMO) || (kind == RK_TMO_SRQ);
          srq_q   <= (kind == RK_END_SRQ) || (kind == RK_TMO_SRQ);
        end
      end else if (phase_q == PH_IDLE && req_valid_i) begin
        if (len_ok) begin
          phase_q <= PH_TX;
          st_q    <= ST_CMD;
          dir_q   <= 1'b1;
          out_q   <= req_cmd_i;
          idx_q   <= '0;
          len_q   <= req_len_i;
          rexp_q  <= req_reply_i;
          data_q  <= req_data_i;
        end else begin
          rej_q <= 1'b1;
        end
      end else if (phase_q == PH_TX && sr_done_i) begin
        if (tx_last) begin
          dir_q <= 1'b0;
          if (rexp_q) begin
            phase_q   <= PH_RX;
            st_q      <= ST_EVEN;
            first_q   <= 1'b1;
            prevctl_q <= 1'b1;
            sol_q     <= 1'b1;
          end else begin
            phase_q <= PH_IDLE;
            st_q    <= ST_IDLE;
            done_q  <= 1'b1;
            sol_q   <= 1'b0;
          end
        end else begin
          out_q <= tx_byte;
          idx_q <= idx_q + 1'b1;
          st_q  <= (st_q == ST_CMD) ? ST_EVEN : adb_st_e'(~st_q);
        end
      end
    end
  end

  assign req_ready_o = (phase_q == PH_IDLE) && !sr_done_i;
  assign req_rej_o   = rej_q;
  assign sr_out_o    = out_q;
  assign sr_dir_o    = dir_q;
  assign st_o        = st_q;
  assign done_o      = done_q;
  assign tmo_o       = tmo_q;
  assign srq_o       = srq_q;
  assign rply_sol_o  = sol_q;
endmodule

// File: rtl/adb_seq_chk.sv
module adb_seq_chk #(
  parameter int MAX_TX = 14,
  parameter int MAX_RX = 15,
  parameter int TLW    = 4,
  parameter int RLW    = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_valid_i,
  input logic           req_ready_o,
  input logic [7:0]     req_cmd_i,
  input logic [TLW-1:0] req_len_i,
  input logic           req_rej_o,
  input logic           sr_done_i,
  input logic [7:0]     sr_out_o,
  input logic           sr_dir_o,
  input logic [1:0]     st_o,
  input logic           done_o,
  input logic           tmo_o,
  input logic           srq_o,
  input logic [RLW-1:0] rply_len_o
);
  assert_cmd_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_len_i != '0 && req_len_i <= TLW'(MAX_TX)
    |=> st_o == 2'b00 && sr_dir_o && sr_out_o == $past(req_cmd_i));

  assert_reject_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_rej_o |-> st_o == 2'b11 && !sr_dir_o);

  assert_cmd_to_even_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_done_i && sr_dir_o && st_o == 2'b00 |=> st_o == 2'b01 && sr_dir_o);

  assert_tmo_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> done_o);

  assert_srq_with_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srq_o |-> done_o);

  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rply_len_o <= RLW'(MAX_RX));

  assert_done_idle_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> st_o == 2'b11 && !sr_dir_o);

  assert_done_pulse_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !sr_done_i |=> !done_o);

  assert_busy_not_ready_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_o != 2'b11 |-> !req_ready_o);
endmodule

bind adb_seq adb_seq_chk #(
  .MAX_TX(MAX_TX), .MAX_RX(MAX_RX), .TLW(TLW), .RLW(RLW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .req_cmd_i(req_cmd_i), .req_len_i(req_len_i),
  .req_rej_o(req_rej_o), .sr_done_i(sr_done_i), .sr_out_o(sr_out_o),
  .sr_dir_o(sr_dir_o), .st_o(st_o), .done_o(done_o), .tmo_o(tmo_o),
  .srq_o(srq_o), .rply_len_o(rply_len_o)
);

// File: tb/test_adb_seq.sv
module test_adb_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_TX = 14;
  localparam int MAX_RX = 15;
  localparam int TLW = 4;
  localparam int RLW = 4;

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic                req_valid = 1'b0, req_ready, req_reply = 1'b0, req_rej;
  logic [7:0]          req_cmd = '0, sr_in = '0, sr_out;
  logic [MAX_TX*8-1:0] req_data = '0;
  logic [TLW-1:0]      req_len = '0;
  logic                sr_done = 1'b0, sr_dir, ctl_n = 1'b1;
  logic [1:0]          st;
  logic                done, tmo, srq, sol;
  logic [RLW-1:0]      rlen;
  logic [MAX_RX*8-1:0] rdata;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adb_seq #(.MAX_TX(MAX_TX), .MAX_RX(MAX_RX), .TLW(TLW), .RLW(RLW)) i_adb_seq (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_cmd_i(req_cmd), .req_data_i(req_data), .req_len_i(req_len),
    .req_reply_i(req_reply), .req_rej_o(req_rej), .sr_done_i(sr_done),
    .sr_in_i(sr_in), .sr_out_o(sr_out), .sr_dir_o(sr_dir), .st_o(st),
    .ctl_n_i(ctl_n), .done_o(done), .tmo_o(tmo), .srq_o(srq),
    .rply_sol_o(sol), .rply_len_o(rlen), .rply_data_o(rdata)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] b, input logic c);
    sr_done = 1'b1; sr_in = b; ctl_n = c;
    @(negedge clk);
    sr_done = 1'b0; ctl_n = 1'b1;
  endtask

  task automatic send_req(input logic [7:0] cmd, input int len, input logic rep);
    req_cmd = cmd; req_len = TLW'(len); req_reply = rep;
    for (int k = 0; k < MAX_TX; k++) req_data[k*8 +: 8] = 8'hA0 + 8'(k);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // phase after a stored byte: k bytes stored starting from even
  function automatic logic [1:0] rx_phase(input int k);
    return (k % 2 == 1) ? 2'b10 : 2'b01;
  endfunction

  task automatic t_reset();
    chk("R1 phase", st, 2'b11);
    chk("R1 dir", sr_dir, 1'b0);
    chk("R1 len", rlen, 0);
    chk("R1 data", rdata, 0);
    chk("R1 done", {done, tmo, srq, req_rej}, 0);
    chk("R1 ready", req_ready, 1'b1);
  endtask

  task automatic t_send_noreply();
    send_req(8'h2B, 3, 1'b0);
    chk("R2 phase", st, 2'b00);
    chk("R2 dir", sr_dir, 1'b1);
    chk("R2 out", sr_out, 8'h2B);
    for (int k = 0; k < 3; k++) begin
      if (k == 1) begin
        chk("R13 ready busy", req_ready, 1'b0);
        req_cmd = 8'h77; req_len = 4'd2; req_valid = 1'b1;
      end
      strobe(8'h00, 1'b1);
      req_valid = 1'b0;
      chk("R4 out", sr_out, 8'hA0 + 8'(k));
      chk("R4 phase", st, (k % 2 == 0) ? 2'b01 : 2'b10);
    end
    strobe(8'h00, 1'b1);
    chk("R5 phase", st, 2'b11);
    chk("R5 dir", sr_dir, 1'b0);
    chk("R5 done", {done, tmo, srq}, 3'b100);
    chk("R5 len", rlen, 0);
    chk("R5 sol", sol, 1'b0);
    @(negedge clk);
    chk("R13 done pulse", done, 1'b0);
  endtask

  task automatic open_reply(input logic [7:0] cmd);
    send_req(cmd, 1, 1'b1);
    strobe(8'h00, 1'b1);
    strobe(8'h00, 1'b1);
    chk("R6 phase", st, 2'b01);
    chk("R6 dir", sr_dir, 1'b0);
    chk("R6 no done", done, 1'b0);
  endtask

  task automatic t_reply(input int n, input logic srq_end);
    logic [MAX_RX*8-1:0] e = '0;
    int stored;
    open_reply(8'h3C);
    for (int k = 0; k < n; k++) begin
      strobe(8'h40 + 8'(k), (srq_end && k == n - 1) ? 1'b0 : 1'b1);
      chk("R7 phase", st, rx_phase(k + 1));
      if (k < MAX_RX) e[k*8 +: 8] = 8'h40 + 8'(k);
    end
    stored = (n > MAX_RX) ? MAX_RX : n;
    strobe(8'h00, 1'b0);
    chk("R10 done", {done, tmo, srq}, {1'b1, 1'b0, srq_end});
    chk("R10 len", rlen, stored);
    chk("R7 data", rdata, e);
    chk("R12 sol", sol, 1'b1);
    if (n > MAX_RX) chk("R11 saturate", rlen, MAX_RX);
  endtask

  task automatic t_tmo();
    open_reply(8'h1C);
    strobe(8'hFF, 1'b1);
    chk("R8 flags", {done, tmo, srq}, 3'b110);
    chk("R8 len", rlen, 0);
    chk("R8 phase", st, 2'b11);
  endtask

  task automatic t_tmo_srq();
    open_reply(8'h2C);
    strobe(8'h5A, 1'b0);
    chk("R9 first stored", rlen, 1);
    chk("R9 phase", st, 2'b10);
    strobe(8'hFF, 1'b0);
    chk("R9 flags", {done, tmo, srq}, 3'b111);
    chk("R9 len", rlen, 0);
  endtask

  task automatic t_reject();
    req_len = 4'd0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 rej len0", req_rej, 1'b1);
    chk("R3 phase", {st, sr_dir, req_ready}, 4'b1101);
    req_len = 4'd15; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 rej len15", req_rej, 1'b1);
    chk("R3 phase 15", {st, sr_dir}, 3'b110);
    @(negedge clk);
    chk("R3 pulse", req_rej, 1'b0);
  endtask

  task automatic t_unsol();
    strobe(8'h55, 1'b1);
    chk("R12 phase", st, 2'b01);
    chk("R13 ready rx", req_ready, 1'b0);
    strobe(8'h00, 1'b1);
    chk("R7 zero stored phase", st, 2'b10);
    strobe(8'h00, 1'b0);
    chk("R12 done", {done, tmo, srq}, 3'b100);
    chk("R7 len", rlen, 2);
    chk("R7 data", rdata, {{(MAX_RX-2)*8{1'b0}}, 8'h00, 8'h55});
    chk("R12 sol", sol, 1'b0);
    strobe(8'hFF, 1'b1);
    chk("R8 idle tmo", {done, tmo, srq, sol}, 4'b1100);
    chk("R8 idle len", rlen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_send_noreply();
    t_reply(2, 1'b0);
    t_reply(3, 1'b1);
    t_reply(17, 1'b0);
    t_tmo();
    t_tmo_srq();
    t_reject();
    t_unsol();
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    end
    $finish;
  end
endmodule